// File: doc/BRIEF.md
# Store Address Monitor Unit

This unit watches a single line-sized window of the address space on behalf of a monitor/wait instruction pair. An arm request presents a linear address with an extensions word and a hints word. If the unit is enabled and the extensions word is zero, the request is accepted. The unit then latches the line-aligned base of the address and moves to the armed state. A request from a disabled unit returns an illegal-opcode response. A request with any extension bit set returns a general-protection response. Neither failed request changes the unit's state. The hints word is accepted and has no effect.

While the unit is armed, it snoops the stream of committed stores. A store sets the triggered state when it is tagged as write-back memory and its address lies in the same line as the latched base. A wait-side consumer samples `armed_o` and `triggered_o`, and a clear pulse from that consumer returns the unit to idle. The line size is a parameter, and the unit reports it on a constant query output.

Top module: `store_watch_unit`

## Requirements
- R1: An arm request with `enable_i` high and `arm_ext_i` equal to zero produces a response with code 2'b00 in the next cycle. In that cycle `armed_o` is 1 and `triggered_o` is 0.
- R2: The store's memory-type tag must be 3'd6 (write-back). The line of the store address is found by shifting the address right by log2(LINE_BYTES). When such a store hits the latched line while `armed_o` is 1, the next cycle shows `triggered_o` at 1 and `armed_o` at 0. A store to any other line leaves the state unchanged, and so does any store while the unit is idle.
- R3: A store with any memory-type tag other than 3'd6 leaves the state unchanged, even when its address hits the latched line.
- R4: An enabled arm request with any non-zero bit in `arm_ext_i` produces response code 2'b01 in the next cycle and leaves `armed_o`, `triggered_o` and the latched line unchanged.
- R5: The value of `arm_hint_i` has no effect on the response or on the state.
- R6: An arm request made while `enable_i` is low produces response code 2'b10, whatever the value of `arm_ext_i`. It leaves the state unchanged.
- R7: `line_size_o` always equals LINE_BYTES.
- R8: An accepted arm request replaces the latched line and clears `triggered_o`. After it, stores to the previous line no longer trigger.
- R9: A `wait_clear_i` pulse returns the unit to idle in the next cycle, with `armed_o` and `triggered_o` both 0. An accepted arm in the same cycle overrides the clear.
- R10: When an accepted arm request and a store arrive in the same cycle, the arm takes effect. The store is not checked against either line, and the unit ends up armed and not triggered.
- R11: `arm_resp_valid_o` is high for exactly the one cycle after each arm request and is low at all other times.
- R12: After reset, `armed_o`, `triggered_o` and `arm_resp_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Global enable; low turns arm requests into illegal-opcode responses |
| arm_valid_i | input | 1 | Arm request strobe |
| arm_addr_i | input | ADDR_W | Linear address of the arm request |
| arm_ext_i | input | EXT_W | Extensions word; must be zero |
| arm_hint_i | input | HINT_W | Hints word; ignored |
| arm_resp_valid_o | output | 1 | One-cycle response pulse |
| arm_resp_code_o | output | 2 | 00 ok, 01 general protection, 10 illegal opcode |
| st_valid_i | input | 1 | Committed store strobe |
| st_addr_i | input | ADDR_W | Store address |
| st_mtype_i | input | MT_W | Store memory-type tag, 6 = write-back |
| wait_clear_i | input | 1 | Wait-side clear, returns to idle |
| armed_o | output | 1 | Monitor armed and not yet triggered |
| triggered_o | output | 1 | A qualifying store hit the line |
| line_size_o | output | QUERY_W | Monitored line size in bytes |

## Verification
The hardest state to reach from the ports is the pair of simultaneous events where the ordering rules decide the outcome. The first is an arm and a store in one cycle, where the store targets the new line. The second is an arm and a clear in one cycle. The bench first arms line A. It then issues the arm of line B and a write-back store to B in the same cycle. After that it probes A and B with separate stores, which shows whether the store was dropped and the old range released. The line-matching logic is covered by sweeping every store address in the 12-bit space against several arm bases, including unaligned ones.

// File: rtl/swu_pkg.sv
// Package: shared types for the store address monitor unit.
// Assumes nothing beyond standard SystemVerilog enum semantics.
package swu_pkg;

    // Response codes returned on an arm request.
    typedef enum logic [1:0] {
        RESP_OK = 2'b00,
        RESP_GP = 2'b01,
        RESP_UD = 2'b10
    } resp_code_t;

    // Monitor states.
    typedef enum logic [1:0] {
        MON_IDLE  = 2'b00,
        MON_ARMED = 2'b01,
        MON_TRIG  = 2'b10
    } mon_state_t;

endpackage

// File: rtl/swu_arm_check.sv
// Module: swu_arm_check
// Decides whether an arm request is accepted and which response code it gets.
// The disable check comes before the extensions check. No extension bit is
// defined, so every set bit faults. The hints word never enters this logic.
module swu_arm_check
    import swu_pkg::*;
#(
    parameter int EXT_W = 32
) (
    input  logic             enable_i,
    input  logic [EXT_W-1:0] ext_i,
    output logic             accept_o,
    output resp_code_t       code_o
);

    // Classify the request: disabled, bad extensions or good.
    always_comb begin
        if (!enable_i) begin
            accept_o = 1'b0;
            code_o   = RESP_UD;
        end else if (|ext_i) begin
            accept_o = 1'b0;
            code_o   = RESP_GP;
        end else begin
            accept_o = 1'b1;
            code_o   = RESP_OK;
        end
    end

endmodule

// File: rtl/swu_line_match.sv
// Module: swu_line_match
// Holds the line tag of the monitored range and compares store addresses
// against it. Assumes LINE_BYTES is a power of two and smaller than 2**ADDR_W.
module swu_line_match #(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              hit_o
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic [TAG_W-1:0] base_tag_q;
    logic [TAG_W-1:0] probe_tag;

    // Latch the aligned tag of a newly accepted arm address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_tag_q <= '0;
        end else if (load_i) begin
            base_tag_q <= load_addr_i[ADDR_W-1:OFF_W];
        end
    end

    // Compare the store's line tag against the latched tag.
    always_comb begin
        probe_tag = probe_addr_i[ADDR_W-1:OFF_W];
        hit_o     = (probe_tag == base_tag_q);
    end

endmodule

// File: rtl/swu_monitor_fsm.sv
// Module: swu_monitor_fsm
// Three-state monitor. An accepted arm has top priority, then a clear, then a
// qualifying store hit. Assumes store_hit_i is already qualified by store
// valid, memory type and line match.
module swu_monitor_fsm
    import swu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_accept_i,
    input  logic clear_i,
    input  logic store_hit_i,
    output logic armed_o,
    output logic triggered_o
);

    mon_state_t state_q;
    mon_state_t state_d;

    // Next-state selection in priority order: arm, clear, store hit.
    always_comb begin
        state_d = state_q;
        if (arm_accept_i) begin
            state_d = MON_ARMED;
        end else if (clear_i) begin
            state_d = MON_IDLE;
        end else if (store_hit_i && state_q == MON_ARMED) begin
            state_d = MON_TRIG;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode the state onto the outputs.
    always_comb begin
        armed_o     = (state_q == MON_ARMED);
        triggered_o = (state_q == MON_TRIG);
    end

    // R2
    hit_triggers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && store_hit_i && !arm_accept_i && !clear_i) |=> triggered_o);

    // R9
    clear_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !arm_accept_i) |=> (!armed_o && !triggered_o));

    // R1
    state_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_o && triggered_o));

endmodule

// File: rtl/store_watch_unit.sv
// Module: store_watch_unit
// Top level of the store address monitor. It validates arm requests, latches
// the monitored line, qualifies snooped stores by memory type and line, and
// drives a registered one-cycle response. Assumes one arm request at most per
// cycle and inputs synchronous to clk.
module store_watch_unit
    import swu_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 16,
    parameter int EXT_W      = 32,
    parameter int HINT_W     = 32,
    parameter int MT_W       = 3,
    parameter int MT_WB      = 6,
    parameter int QUERY_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               arm_valid_i,
    input  logic [ADDR_W-1:0]  arm_addr_i,
    input  logic [EXT_W-1:0]   arm_ext_i,
    input  logic [HINT_W-1:0]  arm_hint_i,
    output logic               arm_resp_valid_o,
    output logic [1:0]         arm_resp_code_o,
    input  logic               st_valid_i,
    input  logic [ADDR_W-1:0]  st_addr_i,
    input  logic [MT_W-1:0]    st_mtype_i,
    input  logic               wait_clear_i,
    output logic               armed_o,
    output logic               triggered_o,
    output logic [QUERY_W-1:0] line_size_o
);

    localparam logic [MT_W-1:0] WB_TAG = MT_W'(MT_WB);

    logic       chk_accept;
    resp_code_t chk_code;
    logic       arm_go;
    logic       line_hit;
    logic       store_qual;
    logic       hint_unused;

    // The hints word is architecturally meaningless; fold it away.
    assign hint_unused = ^arm_hint_i;

    // Report the configured line size on the query output.
    assign line_size_o = QUERY_W'(LINE_BYTES);

    swu_arm_check #(.EXT_W(EXT_W)) u_check (
        .enable_i (enable_i),
        .ext_i    (arm_ext_i),
        .accept_o (chk_accept),
        .code_o   (chk_code)
    );

    // An arm takes effect only when requested and accepted.
    assign arm_go = arm_valid_i && chk_accept;

    swu_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (arm_go),
        .load_addr_i  (arm_addr_i),
        .probe_addr_i (st_addr_i),
        .hit_o        (line_hit)
    );

    // Only write-back stores that hit the line qualify.
    assign store_qual = st_valid_i && (st_mtype_i == WB_TAG) && line_hit;

    swu_monitor_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_accept_i (arm_go),
        .clear_i      (wait_clear_i),
        .store_hit_i  (store_qual),
        .armed_o      (armed_o),
        .triggered_o  (triggered_o)
    );

    // Register the one-cycle response pulse and its code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_resp_valid_o <= 1'b0;
            arm_resp_code_o  <= 2'b00;
        end else begin
            arm_resp_valid_o <= arm_valid_i;
            arm_resp_code_o  <= arm_valid_i ? chk_code : 2'b00;
        end
    end

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_valid_i |=> arm_resp_valid_o);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_valid_i |=> !arm_resp_valid_o);

    // R6
    disabled_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_valid_i && !enable_i) |=> (arm_resp_code_o == 2'b10));

    // R4
    ext_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_valid_i && enable_i && (arm_ext_i != '0)) |=> (arm_resp_code_o == 2'b01));

    // R1
    arm_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_valid_i && enable_i && (arm_ext_i == '0))
            |=> (armed_o && !triggered_o && arm_resp_code_o == 2'b00));

    // R3
    non_wb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && st_valid_i && (st_mtype_i != WB_TAG) && !arm_valid_i && !wait_clear_i)
            |=> armed_o);

    // R4
    fault_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_valid_i && !(enable_i && (arm_ext_i == '0)) && !st_valid_i && !wait_clear_i)
            |=> ($stable(armed_o) && $stable(triggered_o)));

    // R12
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!armed_o && !triggered_o && !arm_resp_valid_o));

endmodule

// File: tb/store_watch_unit_bench.sv
module store_watch_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int LB = 16;
    localparam int OFF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b1;
    logic arm_valid_i = 1'b0;
    logic [AW-1:0] arm_addr_i = '0;
    logic [31:0] arm_ext_i = '0;
    logic [31:0] arm_hint_i = '0;
    logic arm_resp_valid_o;
    logic [1:0] arm_resp_code_o;
    logic st_valid_i = 1'b0;
    logic [AW-1:0] st_addr_i = '0;
    logic [2:0] st_mtype_i = 3'd6;
    logic wait_clear_i = 1'b0;
    logic armed_o, triggered_o;
    logic [15:0] line_size_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [1:0] last_code;
    logic last_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_watch_unit u_store_watch_unit (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .arm_valid_i(arm_valid_i), .arm_addr_i(arm_addr_i),
        .arm_ext_i(arm_ext_i), .arm_hint_i(arm_hint_i),
        .arm_resp_valid_o(arm_resp_valid_o), .arm_resp_code_o(arm_resp_code_o),
        .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_mtype_i(st_mtype_i),
        .wait_clear_i(wait_clear_i), .armed_o(armed_o), .triggered_o(triggered_o),
        .line_size_o(line_size_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Generic one-cycle stimulus: drive at negedge, sample at next negedge.
    task automatic cycle(input logic av, input logic [AW-1:0] aa, input logic [31:0] ae,
                         input logic [31:0] ah, input logic sv, input logic [AW-1:0] sa,
                         input logic [2:0] mt, input logic cl);
        @(negedge clk);
        arm_valid_i = av; arm_addr_i = aa; arm_ext_i = ae; arm_hint_i = ah;
        st_valid_i = sv; st_addr_i = sa; st_mtype_i = mt; wait_clear_i = cl;
        @(negedge clk);
        last_code = arm_resp_code_o;
        last_valid = arm_resp_valid_o;
        arm_valid_i = 1'b0; st_valid_i = 1'b0; wait_clear_i = 1'b0;
    endtask

    task automatic arm(input logic [AW-1:0] a, input logic [31:0] e, input logic [31:0] h);
        cycle(1'b1, a, e, h, 1'b0, '0, 3'd6, 1'b0);
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [2:0] mt);
        cycle(1'b0, '0, '0, '0, 1'b1, a, mt, 1'b0);
    endtask

    initial begin
        logic [AW-1:0] bases [4];
        bases[0] = 12'h000; bases[1] = 12'h035; bases[2] = 12'hFF0; bases[3] = 12'h7A9;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!armed_o && !triggered_o && !arm_resp_valid_o, "R12", {armed_o, triggered_o, arm_resp_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: query port
        chk(line_size_o == LB, "R7", line_size_o, LB);
        // R2: store while idle has no effect
        store(12'h000, 3'd6);
        chk(!armed_o && !triggered_o, "R2 idle store", triggered_o, 0);

        // R1, R2: sweep all store addresses against several bases
        foreach (bases[b]) begin
            arm(bases[b], '0, '0);
            chk(last_valid && last_code == 2'b00 && armed_o && !triggered_o, "R1",
                {last_valid, last_code, armed_o}, 32'b1001);
            for (int s = 0; s < (1 << AW); s++) begin
                logic exp_hit;
                exp_hit = ((s >> OFF) == (bases[b] >> OFF));
                store(AW'(s), 3'd6);
                chk(triggered_o == exp_hit && armed_o == !exp_hit, "R2",
                    {armed_o, triggered_o}, {!exp_hit, exp_hit});
                if (exp_hit) arm(bases[b], '0, '0);
            end
        end

        // R3: every non-write-back tag on a hitting address
        arm(12'h240, '0, '0);
        for (int m = 0; m < 8; m++) begin
            if (m != 6) begin
                store(12'h24F, 3'(m));
                chk(armed_o && !triggered_o, "R3", {armed_o, triggered_o}, 2'b10);
            end
        end

        // R4: each extension bit faults, state and line unchanged
        for (int i = 0; i < 32; i++) begin
            arm(12'h900, 32'(1) << i, '0);
            chk(last_valid && last_code == 2'b01 && armed_o && !triggered_o, "R4",
                {last_valid, last_code, armed_o}, 32'b1011);
        end
        store(12'h900, 3'd6);
        chk(armed_o, "R4 line kept", {armed_o, triggered_o}, 2'b10);
        store(12'h241, 3'd6);
        chk(triggered_o, "R4 old line", {armed_o, triggered_o}, 2'b01);
        // R4: fault while triggered keeps triggered
        arm(12'h500, 32'h8000_0000, '0);
        chk(triggered_o && last_code == 2'b01, "R4 trig kept", {triggered_o, last_code}, 3'b101);

        // R5: hint values ignored
        for (int h = 0; h < 32; h++) begin
            arm(12'h300, '0, 32'(1) << h);
            chk(last_code == 2'b00 && armed_o, "R5", {last_code, armed_o}, 3'b001);
        end
        arm(12'h300, '0, 32'hFFFF_FFFF);
        chk(last_code == 2'b00 && armed_o, "R5 all ones", last_code, 0);
        store(12'h30A, 3'd6);
        chk(triggered_o, "R5 line", triggered_o, 1);

        // R6: disabled arm, with and without extension bits
        enable_i = 1'b0;
        arm(12'h600, '0, '0);
        chk(last_valid && last_code == 2'b10 && triggered_o && !armed_o, "R6",
            {last_valid, last_code, triggered_o}, 32'b1101);
        arm(12'h600, 32'h1, '0);
        chk(last_code == 2'b10 && triggered_o, "R6 over ext", last_code, 2'b10);
        enable_i = 1'b1;

        // R8: rearm replaces line and clears trigger
        arm(12'h700, '0, '0);
        chk(armed_o && !triggered_o, "R8 clear trig", triggered_o, 0);
        store(12'h30A, 3'd6);
        chk(armed_o && !triggered_o, "R8 old line", triggered_o, 0);
        store(12'h70F, 3'd6);
        chk(triggered_o, "R8 new line", triggered_o, 1);

        // R9: clear from triggered and armed; arm beats clear
        cycle(1'b0, '0, '0, '0, 1'b0, '0, 3'd6, 1'b1);
        chk(!armed_o && !triggered_o, "R9 from trig", {armed_o, triggered_o}, 0);
        arm(12'h100, '0, '0);
        cycle(1'b0, '0, '0, '0, 1'b0, '0, 3'd6, 1'b1);
        chk(!armed_o && !triggered_o, "R9 from armed", {armed_o, triggered_o}, 0);
        cycle(1'b1, 12'h180, '0, '0, 1'b0, '0, 3'd6, 1'b1);
        chk(armed_o && !triggered_o, "R9 arm wins", {armed_o, triggered_o}, 2'b10);
        // R9: faulted arm does not block clear
        cycle(1'b1, 12'h180, 32'h4, '0, 1'b0, '0, 3'd6, 1'b1);
        chk(!armed_o && last_code == 2'b01, "R9 fault+clear", {armed_o, last_code}, 3'b001);

        // R10: arm and store to new line together
        arm(12'hA00, '0, '0);
        cycle(1'b1, 12'hB00, '0, '0, 1'b1, 12'hB04, 3'd6, 1'b0);
        chk(armed_o && !triggered_o, "R10 same cycle", {armed_o, triggered_o}, 2'b10);
        store(12'hA04, 3'd6);
        chk(armed_o && !triggered_o, "R10 old line", triggered_o, 0);
        store(12'hB0C, 3'd6);
        chk(triggered_o, "R10 new line", triggered_o, 1);

        // R11: pulse lasts one cycle only
        arm(12'hC00, '0, '0);
        @(negedge clk);
        chk(!arm_resp_valid_o, "R11", arm_resp_valid_o, 0);
        chk(line_size_o == LB, "R7 end", line_size_o, LB);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule